// File: doc/BRIEF.md
# Three-Mode Power and Clock Controller

This block decides which clock domains of a small microcontroller receive a clock. It drives three registered enables: one for the processor core clock, one for the internal system clock that feeds the on-chip peripherals, and one for the clock generator, meaning the oscillator and PLL. Software asks for one of three low-power modes through a request port. Halt stops only the core. Idle stops the core and the system clock but leaves the generator running. Stop switches off everything, the generator included.

Wake sources are masked and combined into one wake event, which passes through a short synchronizer. A wake returns the controller to the run state. Leaving halt or idle takes effect at once, because the generator never stopped. Leaving stop first turns the generator back on. All other clocks then stay off through a settling interval, whose length comes from a count input. Only after that interval does run resume. The controller itself runs on an always-on clock.

Generating the clocks and retaining state are outside this block. The enables go to clock gates elsewhere, and those gates keep register and memory contents intact in every mode.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, `pm_state` is 0 (run) and `core_clk_en`, `sys_clk_en` and `gen_clk_en` are all 1.
- R2: In run, a valid request with code 1 moves `pm_state` to 1 (halt) at the next clock edge. Halt gives core 0, system 1, generator 1.
- R3: In run, a valid request with code 2 moves `pm_state` to 2 (idle) at the next edge. Idle gives core 0, system 0, generator 1.
- R4: In run, a valid request with code 3 moves `pm_state` to 3 (stop) at the next edge. Stop gives all three enables 0.
- R5: In run, a request with code 0, or any request with `req_valid` low, leaves the state and the enables unchanged.
- R6: The wake event is the OR of `wake_src & wake_mask`. It is seen by the mode logic `SYNC_STAGES` edges after it is sampled, so a wake pulse applied before edge k acts at edge k+`SYNC_STAGES`. A source whose mask bit is 0 has no effect.
- R7: A wake event seen in halt or idle returns `pm_state` to 0 at that edge, with all enables 1 and no settling wait.
- R8: A wake event seen in stop moves `pm_state` to 4 (settle) and captures `settle_cycles`. Settle gives core 0, system 0, generator 1. It lasts `settle_cycles`+1 cycles and then returns to run. A change of `settle_cycles` during the interval has no effect.
- R9: Mode requests are ignored in halt, idle, stop and settle. After settle ends, the state is run, whatever request was present during settle.
- R10: The enables are flop outputs, so they change only at clock edges. Whenever the core enable is 1, the system enable is 1. Whenever the system enable is 1, the generator enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Mode request strobe |
| req_code | input | 2 | Requested mode: 0 none, 1 halt, 2 idle, 3 stop |
| wake_src | input | NWAKE | Wake source levels |
| wake_mask | input | NWAKE | Per-source wake enable |
| settle_cycles | input | CNT_W | Settling count applied on exit from stop |
| core_clk_en | output | 1 | Processor core clock enable |
| sys_clk_en | output | 1 | System and peripheral clock enable |
| gen_clk_en | output | 1 | Oscillator and PLL enable |
| pm_state | output | 3 | Current state: 0 run, 1 halt, 2 idle, 3 stop, 4 settle |

## Verification
The assertions take for granted that the requests, wake sources, masks and the settling count are stable around each rising edge of the always-on clock. They also take for granted that the wake sources are at least one cycle long, so that the synchronizer captures them. The bench drives every input only on falling edges, and it holds each wake pulse for a full cycle. Requests are raised during every kind of low-power and settle state, and the settling count is changed during an interval, so that the ignore rules are exercised at the ports.

// File: rtl/pcc_pkg.sv
// Package: shared state encoding, request codes and clock-enable bundle for
// the power and clock controller. Assumes one always-on controller clock.
package pcc_pkg;

    typedef enum logic [2:0] {
        PM_RUN    = 3'd0,
        PM_HALT   = 3'd1,
        PM_IDLE   = 3'd2,
        PM_STOP   = 3'd3,
        PM_SETTLE = 3'd4
    } pm_state_e;

    localparam logic [1:0] REQ_NONE = 2'd0;
    localparam logic [1:0] REQ_HALT = 2'd1;
    localparam logic [1:0] REQ_IDLE = 2'd2;
    localparam logic [1:0] REQ_STOP = 2'd3;

    typedef struct packed {
        logic core;
        logic sys;
        logic gen;
    } clk_en_t;

    // Map a state onto the clock domains that may run in it.
    function automatic clk_en_t enables_for(pm_state_e s);
        clk_en_t e;
        case (s)
            PM_RUN:    e = '{core: 1'b1, sys: 1'b1, gen: 1'b1};
            PM_HALT:   e = '{core: 1'b0, sys: 1'b1, gen: 1'b1};
            PM_IDLE:   e = '{core: 1'b0, sys: 1'b0, gen: 1'b1};
            PM_STOP:   e = '{core: 1'b0, sys: 1'b0, gen: 1'b0};
            PM_SETTLE: e = '{core: 1'b0, sys: 1'b0, gen: 1'b1};
            default:   e = '{core: 1'b1, sys: 1'b1, gen: 1'b1};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pcc_wake_sync.sv
// Module: masks the wake sources, ORs them into one event and passes that
// event through STAGES flops into the controller clock domain.
// Assumes: STAGES >= 1; each source pulse lasts at least one clock.
module pcc_wake_sync #(
    parameter int NWAKE  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NWAKE-1:0] wake_src,
    input  logic [NWAKE-1:0] wake_mask,
    output logic             wake_seen
);

    logic raw_wake;
    logic [STAGES-1:0] chain_q;

    // Reduce the enabled sources to one event.
    always_comb begin
        raw_wake = |(wake_src & wake_mask);
    end

    generate
        if (STAGES == 1) begin : g_single
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= raw_wake;
            end
        end else begin : g_chain
            // Shift the event through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], raw_wake};
            end
        end
    endgenerate

    assign wake_seen = chain_q[STAGES-1];

    // Nothing leaves the synchronizer that was not seen at its input.
    assert_wake_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chain_q[0]) |-> $past(raw_wake));

endmodule

// File: rtl/pcc_settle_timer.sv
// Module: down-counter that times the settling interval after stop.
// Loads the count on entry, decrements while running, flags zero.
// Assumes: load and run are never both high.
module pcc_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Capture the count on entry, then step down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt_q <= '0;
        else if (load)                   cnt_q <= load_val;
        else if (run && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // While running, the count falls by exactly one per cycle.
    assert_settle_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // A running count is not disturbed by the load value changing.
    assert_settle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/pcc_mode_fsm.sv
// Module: mode state machine. Accepts requests only in run, leaves halt and
// idle straight to run on a wake, and leaves stop through the settle state.
// Assumes: wake is already synchronous to clk.
module pcc_mode_fsm
    import pcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_code,
    input  logic       wake,
    input  logic       settle_done,
    output pm_state_e  state_q,
    output pm_state_e  state_d,
    output logic       settle_load,
    output logic       settle_run
);

    // Next-state decision.
    always_comb begin
        state_d     = state_q;
        settle_load = 1'b0;
        case (state_q)
            PM_RUN: begin
                if (req_valid) begin
                    case (req_code)
                        REQ_HALT: state_d = PM_HALT;
                        REQ_IDLE: state_d = PM_IDLE;
                        REQ_STOP: state_d = PM_STOP;
                        default:  state_d = PM_RUN;
                    endcase
                end
            end
            PM_HALT, PM_IDLE: begin
                if (wake) state_d = PM_RUN;
            end
            PM_STOP: begin
                if (wake) begin
                    state_d     = PM_SETTLE;
                    settle_load = 1'b1;
                end
            end
            PM_SETTLE: begin
                if (settle_done) state_d = PM_RUN;
            end
            default: state_d = PM_RUN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PM_RUN;
        else        state_q <= state_d;
    end

    assign settle_run = (state_q == PM_SETTLE);

    assert_halt_idle_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PM_HALT || state_q == PM_IDLE) && wake) |=> state_q == PM_RUN);

    assert_stop_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_STOP && wake) |=> state_q == PM_SETTLE);

    assert_lowpower_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == PM_HALT || state_q == PM_IDLE || state_q == PM_STOP) && !wake)
        |=> $stable(state_q));

    assert_settle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_SETTLE && !settle_done) |=> state_q == PM_SETTLE);

    assert_settle_to_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_SETTLE && settle_done) |=> state_q == PM_RUN);

    assert_no_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PM_RUN && (!req_valid || req_code == REQ_NONE)) |=> state_q == PM_RUN);

endmodule

// File: rtl/pcc_gate_regs.sv
// Module: registers the clock enables from the next state so every enable
// is a flop output and changes only on a clock edge.
// Assumes: next_state is settled before each rising edge.
module pcc_gate_regs
    import pcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_state_e next_state,
    output logic      core_en,
    output logic      sys_en,
    output logic      gen_en
);

    clk_en_t en_q;

    // Register the enables that belong to the coming state.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '{core: 1'b1, sys: 1'b1, gen: 1'b1};
        else        en_q <= enables_for(next_state);
    end

    assign core_en = en_q.core;
    assign sys_en  = en_q.sys;
    assign gen_en  = en_q.gen;

    assert_core_needs_sys_R10: assert property (@(posedge clk) disable iff (!rst_n)
        core_en |-> sys_en);

    assert_sys_needs_gen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_en |-> gen_en);

    // The generator restarts before the core is allowed to run.
    assert_gen_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gen_en) |-> !core_en);

endmodule

// File: rtl/pwr_clk_ctrl.sv
// Module: top of the power and clock controller. Ties the wake
// synchronizer, mode state machine, settle timer and enable registers.
// Assumes: clk is an always-on clock independent of the gated domains.
module pwr_clk_ctrl
    import pcc_pkg::*;
#(
    parameter int NWAKE       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_code,
    input  logic [NWAKE-1:0] wake_src,
    input  logic [NWAKE-1:0] wake_mask,
    input  logic [CNT_W-1:0] settle_cycles,
    output logic             core_clk_en,
    output logic             sys_clk_en,
    output logic             gen_clk_en,
    output logic [2:0]       pm_state
);

    logic      wake_seen;
    logic      settle_done;
    logic      settle_load;
    logic      settle_run;
    pm_state_e state_q;
    pm_state_e state_d;

    pcc_wake_sync #(.NWAKE(NWAKE), .STAGES(SYNC_STAGES)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .wake_src  (wake_src),
        .wake_mask (wake_mask),
        .wake_seen (wake_seen)
    );

    pcc_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_code    (req_code),
        .wake        (wake_seen),
        .settle_done (settle_done),
        .state_q     (state_q),
        .state_d     (state_d),
        .settle_load (settle_load),
        .settle_run  (settle_run)
    );

    pcc_settle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (settle_load),
        .load_val (settle_cycles),
        .run      (settle_run),
        .done     (settle_done)
    );

    pcc_gate_regs u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_state (state_d),
        .core_en    (core_clk_en),
        .sys_en     (sys_clk_en),
        .gen_en     (gen_clk_en)
    );

    assign pm_state = state_q;

    // Each state shows its own set of enables at the ports.
    assert_stop_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 3'd3) |-> (!core_clk_en && !sys_clk_en && !gen_clk_en));

    assert_halt_sys_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 3'd1) |-> (!core_clk_en && sys_clk_en && gen_clk_en));

    assert_idle_gen_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_state == 3'd2) |-> (!core_clk_en && !sys_clk_en && gen_clk_en));

endmodule

// File: tb/tb_pwr_clk_ctrl.sv
// Bench: behavioural reference model stepped on each rising edge and
// compared with the ports on each falling edge, plus directed checks.
module tb_pwr_clk_ctrl;

    localparam int NWAKE = 4;
    localparam int SYNC  = 2;
    localparam int CW    = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [1:0]    req_code;
    logic [NWAKE-1:0] wake_src;
    logic [NWAKE-1:0] wake_mask;
    logic [CW-1:0] settle_cycles;
    logic          core_clk_en, sys_clk_en, gen_clk_en;
    logic [2:0]    pm_state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 0;

    // Reference model state.
    int m_state = 0;
    int m_cnt   = 0;
    bit wq[$];

    always #10 clk = ~clk;   // 50 MHz

    pwr_clk_ctrl #(.NWAKE(NWAKE), .SYNC_STAGES(SYNC), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
        .wake_src(wake_src), .wake_mask(wake_mask), .settle_cycles(settle_cycles),
        .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en), .gen_clk_en(gen_clk_en),
        .pm_state(pm_state)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    function automatic int exp_en(int s);
        // packed as {core, sys, gen}
        case (s)
            0: return 7;
            1: return 3;
            2: return 1;
            3: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic string tag_of(int s);
        case (s)
            0: return "R7";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            default: return "R8";
        endcase
    endfunction

    // Step the reference model on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_state = 0;
            m_cnt   = 0;
            wq.delete();
            for (int i = 0; i < SYNC; i++) wq.push_back(1'b0);
        end else begin
            bit w;
            wq.push_back(|(wake_src & wake_mask));
            w = wq.pop_front();
            case (m_state)
                0: if (req_valid && req_code != 2'd0) m_state = int'(req_code);
                1, 2: if (w) m_state = 0;
                3: if (w) begin m_state = 4; m_cnt = int'(settle_cycles); end
                default: if (m_cnt == 0) m_state = 0; else m_cnt--;
            endcase
        end
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 5000);
            finish_run();
        end
    end

    // Compare the ports with the model away from the active edge.
    always @(negedge clk) begin
        if (cycles > 0) begin
            chk(tag_of(m_state), int'(pm_state), m_state);
            chk("R10", int'({core_clk_en, sys_clk_en, gen_clk_en}), exp_en(m_state));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(logic [1:0] code);
        req_valid = 1'b1; req_code = code;
        tick(1);
        req_valid = 1'b0; req_code = 2'd0;
    endtask

    task automatic pulse_wake(logic [NWAKE-1:0] v);
        wake_src = v;
        tick(1);
        wake_src = '0;
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_code = 2'd0;
        wake_src = '0; wake_mask = 4'b0101; settle_cycles = 8'd5;
        tick(3);
        chk("R1", int'(pm_state), 0);
        chk("R1", int'({core_clk_en, sys_clk_en, gen_clk_en}), 7);
        rst_n = 1'b1;

        // R5: no-op requests in run
        request(2'd0);
        req_valid = 1'b0; req_code = 2'd3; tick(1); req_code = 2'd0;
        chk("R5", int'(pm_state), 0);
        chk("R5", int'({core_clk_en, sys_clk_en, gen_clk_en}), 7);

        // R2: halt, then ignored request, masked and enabled wake
        request(2'd1);
        chk("R2", int'({core_clk_en, sys_clk_en, gen_clk_en}), 3);
        request(2'd3); tick(1);
        chk("R9", int'(pm_state), 1);
        pulse_wake(4'b1010); tick(4);
        chk("R6", int'(pm_state), 1);
        pulse_wake(4'b0001); tick(1);
        chk("R6", int'(pm_state), 1);
        tick(1);
        chk("R7", int'(pm_state), 0);
        chk("R7", int'({core_clk_en, sys_clk_en, gen_clk_en}), 7);

        // R3: idle and wake through the other enabled source
        request(2'd2);
        chk("R3", int'({core_clk_en, sys_clk_en, gen_clk_en}), 1);
        request(2'd1);
        chk("R9", int'(pm_state), 2);
        pulse_wake(4'b0100); tick(2);
        chk("R7", int'(pm_state), 0);

        // R4/R8: stop, settle of 5, count change and request during settle
        request(2'd3);
        chk("R4", int'({core_clk_en, sys_clk_en, gen_clk_en}), 0);
        request(2'd2);
        chk("R9", int'(pm_state), 3);
        pulse_wake(4'b0001); tick(2);
        chk("R8", int'(pm_state), 4);
        chk("R8", int'({core_clk_en, sys_clk_en, gen_clk_en}), 1);
        settle_cycles = 8'd0;
        req_valid = 1'b1; req_code = 2'd1;
        tick(5);
        chk("R9", int'(pm_state), 4);
        req_valid = 1'b0; req_code = 2'd0;
        tick(1);
        chk("R8", int'(pm_state), 0);

        // R8: zero settle count lasts one cycle
        request(2'd3);
        pulse_wake(4'b0100); tick(2);
        chk("R8", int'(pm_state), 4);
        tick(1);
        chk("R8", int'(pm_state), 0);

        // R2 again after stop, then back out
        request(2'd1);
        chk("R2", int'(pm_state), 1);
        pulse_wake(4'b0001); tick(2);
        chk("R7", int'(pm_state), 0);
        tick(3);
        finish_run();
    end

endmodule